// File: doc/BRIEF.md
# Reachability Closure Engine

The engine holds a square Boolean adjacency matrix over N nodes and turns it, in place, into the reflexive-transitive closure of that relation. A start pulse captures the relation from a flat input vector and forces every diagonal entry to one. The engine then runs a fixed number of squaring steps, one per clock. Each step ORs the matrix with its own Boolean product, so the longest path it covers doubles every step.

After log2(N) steps the engine raises `done`. It then answers point queries of the form "is node `q_dst` reachable from node `q_src`?" in the same cycle. It also presents the number of set entries of the closure on a registered count. That count is loaded once, on the cycle the last step completes, so the output needs no population logic.

A new start pulse abandons any result, or any computation in flight, and begins again from the new relation.

Top module: `reach_closure`

## Requirements
- R1: After reset `busy`, `done`, `q_hit` are 0 and `card` is 0.
- R2: A cycle with `start` high captures `rel_in`, where bit index `i*N+j` set means an edge from node i to node j. In the next cycle `busy` is 1 and `done` is 0.
- R3: Squaring takes one cycle per step and there are log2(N) steps. `done` rises, and `busy` falls, on the log2(N)-th clock edge after the edge that sampled `start`. `busy` and `done` are never both 1.
- R4: While `done` is 1, `q_hit` equals `q_valid` AND (node `q_dst` is reachable from node `q_src` by a directed path of zero or more edges of the captured relation). It answers in the same cycle, from the combinational query inputs.
- R5: Every diagonal pair (`q_src` equal to `q_dst`) is a member of the closure once `done` is 1.
- R6: While `done` is 1, `card` equals the number of member pairs of the closure, which is at least N. While `done` is 0, `card` is 0.
- R7: Queries are ignored unless `done` is 1: `q_hit` stays 0 while the engine is idle or busy.
- R8: A `start` while busy or done clears `done` and `card` on the next edge and restarts from the newly presented relation.
- R9: Without a new `start`, `done`, `card` and all query answers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture `rel_in` and begin the closure |
| rel_in | input | N*N | Relation, bit i*N+j is edge i to j |
| q_valid | input | 1 | Query strobe |
| q_src | input | log2(N) | Query source node |
| q_dst | input | log2(N) | Query destination node |
| busy | output | 1 | Squaring steps in progress |
| done | output | 1 | Closure complete, queries answered |
| q_hit | output | 1 | Query pair is a closure member |
| card | output | clog2(N*N+1) | Number of member pairs in the closure |

## Verification
The engine is fed an empty relation, which leaves only the diagonal and shows that the reflexive entries are added. It also gets a single directed chain through all nodes, whose far end is reached only if every squaring step runs. A directed ring must saturate the whole matrix, and a symmetric random relation must produce a symmetric closure. Sparse random relations cover mixed component shapes. A restart in the middle of a computation shows that no state leaks from the abandoned run. Every pair is swept by query after each closure, and random queries during the busy phase confirm that the answer is gated.

// File: rtl/closure_pkg.sv
package closure_pkg;
  typedef enum logic [1:0] {
    CL_IDLE   = 2'd0,
    CL_SQUARE = 2'd1,
    CL_HOLD   = 2'd2
  } cl_state_e;
endpackage

// File: rtl/closure_square.sv
module closure_square #(
  parameter int N = 8,
  localparam int NN = N * N
) (
  input  logic [NN-1:0] m_cur,
  output logic [NN-1:0] m_nxt
);
  // Boolean product entry (i,j): some k with i->k and k->j
  function automatic logic two_hop(input logic [NN-1:0] mm, input int i, input int j);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N; k++) r = r | (mm[i*N+k] & mm[k*N+j]);
    return r;
  endfunction

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign m_nxt[gi*N+gj] = m_cur[gi*N+gj] | two_hop(m_cur, gi, gj);
    end
  end
endmodule

// File: rtl/closure_popcount.sv
module closure_popcount #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  function automatic logic [CW-1:0] ones_in(input logic [W-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int k = 0; k < W; k++) r = r + {{(CW-1){1'b0}}, v[k]};
    return r;
  endfunction

  assign cnt = ones_in(vec);
endmodule

// File: rtl/closure_ctrl.sv
module closure_ctrl
  import closure_pkg::*;
#(
  parameter int LGN = 3,
  localparam int SW = (LGN < 2) ? 1 : $clog2(LGN)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output cl_state_e state,
  output logic      load_en,
  output logic      sq_en,
  output logic      step_last
);
  logic [SW-1:0] step_q;

  assign load_en   = start;
  assign sq_en     = (state == CL_SQUARE) && !start;
  assign step_last = sq_en && (step_q == SW'(LGN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CL_IDLE;
      step_q <= '0;
    end else if (start) begin
      state  <= CL_SQUARE;
      step_q <= '0;
    end else if (sq_en) begin
      if (step_last) state <= CL_HOLD;
      else step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/reach_closure.sv
module reach_closure
  import closure_pkg::*;
#(
  parameter int N = 8,
  localparam int LGN = $clog2(N),
  localparam int NN  = N * N,
  localparam int CW  = $clog2(NN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NN-1:0]  rel_in,
  input  logic           q_valid,
  input  logic [LGN-1:0] q_src,
  input  logic [LGN-1:0] q_dst,
  output logic           busy,
  output logic           done,
  output logic           q_hit,
  output logic [CW-1:0]  card
);
  function automatic logic [NN-1:0] ident_mask();
    logic [NN-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) r[k*N+k] = 1'b1;
    return r;
  endfunction

  cl_state_e     state;
  logic          load_en, sq_en, step_last;
  logic [NN-1:0] mat_q, mat_sq;
  logic [CW-1:0] sq_count;

  closure_ctrl #(.LGN(LGN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state),
    .load_en(load_en), .sq_en(sq_en), .step_last(step_last)
  );

  closure_square #(.N(N)) u_square (.m_cur(mat_q), .m_nxt(mat_sq));

  closure_popcount #(.W(NN), .CW(CW)) u_count (.vec(mat_sq), .cnt(sq_count));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mat_q <= '0;
      card  <= '0;
    end else if (load_en) begin
      mat_q <= rel_in | ident_mask();
      card  <= '0;
    end else if (sq_en) begin
      mat_q <= mat_sq;
      if (step_last) card <= sq_count;
    end
  end

  assign busy  = (state == CL_SQUARE);
  assign done  = (state == CL_HOLD);
  assign q_hit = q_valid && done && mat_q[{q_src, q_dst}];
endmodule

// File: rtl/closure_chk.sv
module closure_chk #(
  parameter int N = 8,
  localparam int LGN = $clog2(N),
  localparam int CW  = $clog2(N * N + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           q_valid,
  input logic [LGN-1:0] q_src,
  input logic [LGN-1:0] q_dst,
  input logic           busy,
  input logic           done,
  input logic           q_hit,
  input logic [CW-1:0]  card,
  input logic           step_last
);
  p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && card == '0));

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> done);

  p_hit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> done);

  p_reflexive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_valid && q_src == q_dst) |-> q_hit);

  p_card_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> card == '0);

  p_card_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> card >= CW'(N));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(card)));
endmodule

bind reach_closure closure_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .q_valid(q_valid),
  .q_src(q_src), .q_dst(q_dst), .busy(busy), .done(done),
  .q_hit(q_hit), .card(card), .step_last(step_last)
);

// File: tb/reach_closure_tb_top.sv
module reach_closure_tb_top;
  localparam int N   = 8;
  localparam int LGN = $clog2(N);
  localparam int NN  = N * N;
  localparam int CW  = $clog2(NN + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [NN-1:0]  rel_in = '0;
  logic           q_valid = 1'b0;
  logic [LGN-1:0] q_src = '0;
  logic [LGN-1:0] q_dst = '0;
  logic           busy, done, q_hit;
  logic [CW-1:0]  card;

  always #2.5 clk = ~clk;

  reach_closure #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rel_in(rel_in),
    .q_valid(q_valid), .q_src(q_src), .q_dst(q_dst),
    .busy(busy), .done(done), .q_hit(q_hit), .card(card)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0, m_card = 0;
  bit [NN-1:0] m_clos = '0;

  // path search by node-by-node relaxation, unrelated to squaring
  function automatic bit [NN-1:0] ref_closure(input bit [NN-1:0] r);
    bit [NN-1:0] c;
    c = r;
    for (int d = 0; d < N; d++) c[d*N+d] = 1'b1;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (c[i*N+k] && c[k*N+j]) c[i*N+j] = 1'b1;
    return c;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_card = 0; m_left = 0; m_clos = '0;
    end else if (start) begin                // R2, R8
      m_busy = 1; m_done = 0; m_card = 0; m_left = LGN;
      m_clos = ref_closure(rel_in);
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0; m_done = 1; m_card = $countones(m_clos);
      end
    end
    @(negedge clk);
    check_eq("R3", "busy", int'(busy), int'(m_busy));
    check_eq("R3", "done", int'(done), int'(m_done));
    check_eq("R6", "card", int'(card), m_card);
    if (m_done)
      check_eq("R4", "q_hit", int'(q_hit), int'(q_valid && m_clos[{q_src, q_dst}]));
    else
      check_eq("R7", "q_hit", int'(q_hit), 0);
  endtask

  task automatic rand_query();
    q_valid = 1'($urandom);
    q_src   = LGN'($urandom);
    q_dst   = LGN'($urandom);
  endtask

  task automatic launch(input logic [NN-1:0] r);
    rel_in = r;
    start  = 1'b1;
    rand_query();
    tick();
    start = 1'b0;
    check_eq("R2", "busy after start", int'(busy), 1);
  endtask

  task automatic finish_and_sweep();
    for (int c = 0; c < LGN + 2; c++) begin
      rand_query();
      tick();
    end
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        q_valid = 1'b1; q_src = LGN'(s); q_dst = LGN'(d);
        tick();                                // R4, R5, R9
      end
    q_valid = 1'b0;
  endtask

  function automatic logic [NN-1:0] sparse_rand();
    logic [NN-1:0] a, b, c;
    a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
    return a & b & c;
  endfunction

  initial begin
    logic [NN-1:0] chain, ring, sym;
    logic [NN-1:0] t;
    // R1 reset state
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "done", int'(done), 0);
    check_eq("R1", "card", int'(card), 0);
    check_eq("R1", "q_hit", int'(q_hit), 0);

    // empty relation: only the diagonal (R5, R6)
    launch('0);
    finish_and_sweep();
    check_eq("R6", "empty card", int'(card), N);

    // chain 0->1->..->N-1: far end needs every step (R3, R4)
    chain = '0;
    for (int i = 0; i < N - 1; i++) chain[i*N+i+1] = 1'b1;
    launch(chain);
    for (int c = 0; c < LGN - 1; c++) tick();
    check_eq("R3", "done before last step", int'(done), 0);
    tick();
    check_eq("R3", "done on last step", int'(done), 1);
    finish_and_sweep();
    check_eq("R6", "chain card", int'(card), N * (N + 1) / 2);

    // ring saturates the matrix
    ring = '0;
    for (int i = 0; i < N; i++) ring[i*N+((i+1)%N)] = 1'b1;
    launch(ring);
    finish_and_sweep();
    check_eq("R6", "ring card", int'(card), NN);

    // symmetric random
    t = sparse_rand();
    sym = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (t[i*N+j]) begin sym[i*N+j] = 1'b1; sym[j*N+i] = 1'b1; end
    launch(sym);
    finish_and_sweep();

    // restart mid-computation (R8)
    launch(ring);
    tick();
    launch(chain);
    check_eq("R8", "done after restart", int'(done), 0);
    finish_and_sweep();
    check_eq("R8", "card after restart", int'(card), N * (N + 1) / 2);

    // restart while done
    launch('0);
    check_eq("R8", "card cleared", int'(card), 0);
    finish_and_sweep();

    for (int r = 0; r < 4; r++) begin
      launch(sparse_rand());
      finish_and_sweep();
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule